// File: doc/BRIEF.md
# Dual-Bank Flash Program/Erase Sequencer

This block sequences page erase, word programming and one-word info reads on two flash banks. Each bank is a behavioural array holding a main space, made of pages, and a small info space. Software writes a staging buffer and a transfer descriptor (word offset, info select, zero-based word count). It then writes an unlock value to the key register and an opcode to the control register of one bank. The sequencer checks the request. If the request is valid, it holds the bank busy for a fixed number of cycles and applies the result to the array when that time ends.

The control register reads back the running opcode until the operation ends, and writing zero to it abandons the operation. While a bank is busy, every read to it on the memory read port is held off. Rejected requests set bits in an error register, and reading that register clears it.

Register byte addresses: key 0x00, bank-0 control 0x04, bank-1 control 0x08, transfer descriptor 0x0C, error 0x10, info read result 0x14, and staging buffer word i at 0x80 + 4*i. The descriptor holds the offset in bits [15:0], the info select in bit 16 and the word count in bits starting at 24.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset every main word reads 0xFFFFFFFF, the error and both control registers read 0, and rd_ready is high.
- R2: Opcode 0x31415927 sets every word of the page that holds the offset to 0xFFFFFFFF and leaves all other pages unchanged.
- R3: Opcode 0x27182818 replaces words offset..offset+count with (old AND buffer word j) for j = 0..count. The count is zero-based, so count 0 programs exactly one word.
- R4: A nonzero opcode starts only if the last key register write was 0xB11924E1 and no control write has happened since then. Otherwise the opcode is ignored and error bit 0 is set. Every control write, including zero, uses up the key.
- R5: A nonzero control value that is not one of the three opcodes is ignored and sets error bit 1.
- R6: A request whose offset is outside the selected space, or a program whose last word would fall past the end of the page of its first word, is rejected and sets error bit 2. The info space counts as one page.
- R7: Erase with info select, info select on bank 0, or read opcode 0x16021765 without info select is rejected and sets error bit 3.
- R8: A program with info select on bank 1 writes the info space. The read opcode on bank 1 copies the info word at the offset into the result register (0x14) when it completes.
- R9: The control register reads the running opcode for exactly ERASE_CYCLES (erase) or PROG_CYCLES (program, read) cycles after the write edge and 0 after that. A nonzero write while the bank is busy is ignored and sets error bit 4.
- R10: Writing 0 to the control register of a busy bank ends the operation at that edge and leaves the array unchanged.
- R11: rd_ready is low while rd_req targets a busy bank. A request to the other bank is served at once.
- R12: Reading the error register returns the accumulated bits and clears them at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the clear-on-read) |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| rd_req | input | 1 | Memory read request |
| rd_bank | input | 1 | Bank selected by the memory read |
| rd_addr | input | AW | Word address in the main space |
| rd_ready | output | 1 | Low while the read is stalled |
| rd_data | output | 32 | Word read from the selected bank |

## Verification
The bench builds the block with 4 pages of 16 words, a 16-word info space, an 8-word staging buffer, 12 erase cycles and 5 program cycles. With these values a page boundary, the end of a bank and the end of the info space can all be reached using counts the buffer can hold. The exact busy windows are short enough to sample cycle by cycle. The small array also lets the bench check the words next to each program or erase target, as well as the far end of the last page.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'hB119_24E1;
    localparam logic [31:0] OPC_ERASE  = 32'h3141_5927;
    localparam logic [31:0] OPC_PROG   = 32'h2718_2818;
    localparam logic [31:0] OPC_READ   = 32'h1602_1765;

    localparam logic [7:0] A_KEY   = 8'h00;
    localparam logic [7:0] A_CTRL0 = 8'h04;
    localparam logic [7:0] A_CTRL1 = 8'h08;
    localparam logic [7:0] A_XFER  = 8'h0C;
    localparam logic [7:0] A_ERR   = 8'h10;
    localparam logic [7:0] A_DOUT  = 8'h14;

    localparam int ERR_W   = 5;
    localparam int E_NOKEY = 0;
    localparam int E_OPC   = 1;
    localparam int E_RANGE = 2;
    localparam int E_INFO  = 3;
    localparam int E_BUSY  = 4;

    typedef enum logic [1:0] {
        K_ERASE = 2'd0,
        K_PROG  = 2'd1,
        K_READ  = 2'd2
    } op_kind_e;

    function automatic logic [31:0] kind_code(op_kind_e k);
        case (k)
            K_ERASE: return OPC_ERASE;
            K_PROG:  return OPC_PROG;
            default: return OPC_READ;
        endcase
    endfunction

endpackage

// File: rtl/flash_pe_bank.sv
module flash_pe_bank
    import flash_pe_pkg::*;
#(
    parameter int PAGES      = 8,
    parameter int PAGE_WORDS = 64,
    parameter int INFO_WORDS = 32,
    parameter int BUF_WORDS  = 32,
    localparam int BANK_WORDS = PAGES * PAGE_WORDS,
    localparam int AW         = $clog2(BANK_WORDS),
    localparam int PB         = $clog2(PAGE_WORDS),
    localparam int IW         = $clog2(INFO_WORDS),
    localparam int CW         = $clog2(BUF_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  op_kind_e                    kind,
    input  logic                        tgt_info,
    input  logic [AW-1:0]               offset,
    input  logic [CW-1:0]               count,
    input  logic [BUF_WORDS-1:0][31:0]  wbuf,
    input  logic [AW-1:0]               rd_addr,
    output logic [31:0]                 rd_data,
    output logic [31:0]                 info_data
);

    logic [31:0] main_mem [BANK_WORDS];
    logic [31:0] info_mem [INFO_WORDS];

    assign rd_data   = main_mem[rd_addr];
    assign info_data = info_mem[offset[IW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK_WORDS; i++) main_mem[AW'(i)] <= '1;
            for (int i = 0; i < INFO_WORDS; i++) info_mem[IW'(i)] <= '1;
        end else if (commit) begin
            if (kind == K_ERASE) begin
                for (int i = 0; i < PAGE_WORDS; i++)
                    main_mem[{offset[AW-1:PB], PB'(i)}] <= '1;
            end else if (kind == K_PROG) begin
                for (int j = 0; j < BUF_WORDS; j++) begin
                    if (j <= int'(count)) begin
                        if (tgt_info)
                            info_mem[IW'(offset + AW'(j))] <= info_mem[IW'(offset + AW'(j))] & wbuf[j];
                        else
                            main_mem[offset + AW'(j)] <= main_mem[offset + AW'(j)] & wbuf[j];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int PAGES        = 8,
    parameter int PAGE_WORDS   = 64,
    parameter int INFO_WORDS   = 32,
    parameter int BUF_WORDS    = 32,
    parameter int ERASE_CYCLES = 40,
    parameter int PROG_CYCLES  = 12,
    localparam int BANK_WORDS  = PAGES * PAGE_WORDS,
    localparam int AW          = $clog2(BANK_WORDS),
    localparam int CW          = $clog2(BUF_WORDS),
    localparam int MAXC        = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
    localparam int TW          = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          rd_req,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    output logic [31:0]   rd_data
);

    typedef struct packed {
        logic          busy;
        op_kind_e      kind;
        logic          info;
        logic [AW-1:0] off;
        logic [CW-1:0] cnt;
        logic [TW-1:0] timer;
    } bank_st_t;

    typedef struct packed {
        logic                       key;
        logic [ERR_W-1:0]           err;
        logic [15:0]                x_off;
        logic                       x_info;
        logic [CW-1:0]              x_cnt;
        logic [31:0]                dout;
        logic [BUF_WORDS-1:0][31:0] wbuf;
        bank_st_t [1:0]             bk;
    } state_t;

    state_t st_d, st_q;

    logic             key_armed;
    logic [1:0]       busy_vec;
    logic [ERR_W-1:0] err_vec;
    logic [1:0]       commit_c;
    logic [31:0]      main_rd [2];
    logic [31:0]      info_rd [2];

    assign key_armed = st_q.key;
    assign busy_vec  = {st_q.bk[1].busy, st_q.bk[0].busy};
    assign err_vec   = st_q.err;

    // next-state logic
    logic             ctrl_hit, cb, opc_ok, info_bad, range_bad, buf_hit;
    op_kind_e         kind;
    logic [31:0]      lim, span, loc;
    logic [ERR_W-1:0] new_err;

    assign buf_hit = reg_addr[7] && (32'(reg_addr[6:2]) < BUF_WORDS);

    always_comb begin
        st_d     = st_q;
        commit_c = 2'b00;
        new_err  = '0;
        ctrl_hit = reg_wr && (reg_addr == A_CTRL0 || reg_addr == A_CTRL1);
        cb       = (reg_addr == A_CTRL1);

        for (int b = 0; b < 2; b++) begin
            if (st_q.bk[b].busy) begin
                if (st_q.bk[b].timer == TW'(1)) begin
                    st_d.bk[b].busy = 1'b0;
                    commit_c[b]     = 1'b1;
                end else begin
                    st_d.bk[b].timer = st_q.bk[b].timer - TW'(1);
                end
            end
        end

        opc_ok = 1'b1;
        kind   = K_PROG;
        case (reg_wdata)
            OPC_ERASE: kind = K_ERASE;
            OPC_PROG:  kind = K_PROG;
            OPC_READ:  kind = K_READ;
            default:   opc_ok = 1'b0;
        endcase
        info_bad  = (kind == K_ERASE && st_q.x_info) || (kind == K_READ && !st_q.x_info) ||
                    (st_q.x_info && !cb);
        lim       = st_q.x_info ? 32'(INFO_WORDS) : 32'(BANK_WORDS);
        span      = st_q.x_info ? 32'(INFO_WORDS) : 32'(PAGE_WORDS);
        loc       = st_q.x_info ? 32'(st_q.x_off) : (32'(st_q.x_off) % 32'(PAGE_WORDS));
        range_bad = (32'(st_q.x_off) >= lim) ||
                    (kind == K_PROG && (loc + 32'(st_q.x_cnt)) >= span);

        if (reg_wr) begin
            if (reg_addr == A_KEY) st_d.key = (reg_wdata == UNLOCK_KEY);
            if (reg_addr == A_XFER) begin
                st_d.x_off  = reg_wdata[15:0];
                st_d.x_info = reg_wdata[16];
                st_d.x_cnt  = reg_wdata[24 +: CW];
            end
            if (buf_hit) st_d.wbuf[reg_addr[2 +: CW]] = reg_wdata;
        end

        if (ctrl_hit) begin
            st_d.key = 1'b0;
            if (reg_wdata == '0) begin
                if (st_q.bk[cb].busy) begin
                    st_d.bk[cb].busy = 1'b0;
                    commit_c[cb]     = 1'b0;
                end
            end else if (st_q.bk[cb].busy) new_err[E_BUSY] = 1'b1;
            else if (!key_armed)            new_err[E_NOKEY] = 1'b1;
            else if (!opc_ok)               new_err[E_OPC] = 1'b1;
            else if (info_bad)              new_err[E_INFO] = 1'b1;
            else if (range_bad)             new_err[E_RANGE] = 1'b1;
            else begin
                st_d.bk[cb].busy  = 1'b1;
                st_d.bk[cb].kind  = kind;
                st_d.bk[cb].info  = st_q.x_info;
                st_d.bk[cb].off   = st_q.x_off[AW-1:0];
                st_d.bk[cb].cnt   = st_q.x_cnt;
                st_d.bk[cb].timer = (kind == K_ERASE) ? TW'(ERASE_CYCLES) : TW'(PROG_CYCLES);
            end
        end

        if (commit_c[1] && st_q.bk[1].kind == K_READ) st_d.dout = info_rd[1];

        st_d.err = ((reg_rd && reg_addr == A_ERR) ? '0 : err_vec) | new_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // register readback
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL0: reg_rdata = busy_vec[0] ? kind_code(st_q.bk[0].kind) : '0;
            A_CTRL1: reg_rdata = busy_vec[1] ? kind_code(st_q.bk[1].kind) : '0;
            A_XFER: begin
                reg_rdata[15:0]    = st_q.x_off;
                reg_rdata[16]      = st_q.x_info;
                reg_rdata[24 +: CW] = st_q.x_cnt;
            end
            A_ERR:  reg_rdata = 32'(err_vec);
            A_DOUT: reg_rdata = st_q.dout;
            default: if (buf_hit) reg_rdata = st_q.wbuf[reg_addr[2 +: CW]];
        endcase
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        flash_pe_bank #(
            .PAGES      (PAGES),
            .PAGE_WORDS (PAGE_WORDS),
            .INFO_WORDS (INFO_WORDS),
            .BUF_WORDS  (BUF_WORDS)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .commit    (commit_c[g]),
            .kind      (st_q.bk[g].kind),
            .tgt_info  (st_q.bk[g].info),
            .offset    (st_q.bk[g].off),
            .count     (st_q.bk[g].cnt),
            .wbuf      (st_q.wbuf),
            .rd_addr   (rd_addr),
            .rd_data   (main_rd[g]),
            .info_data (info_rd[g])
        );
    end

    assign rd_ready = !(rd_req && busy_vec[rd_bank]);
    assign rd_data  = rd_bank ? main_rd[1] : main_rd[0];

endmodule

module flash_pe_ctrl_chk
    import flash_pe_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             rd_req,
    input logic             rd_bank,
    input logic             rd_ready,
    input logic             key_armed,
    input logic [1:0]       busy,
    input logic [ERR_W-1:0] err
);

    AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_CTRL0 || reg_addr == A_CTRL1)) |=> !key_armed); // R4

    AST_NOKEY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL0 && !key_armed && !busy[0]) |=> !busy[0]); // R4

    AST_ABORT_B0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL0 && reg_wdata == '0 && busy[0]) |=> !busy[0]); // R10

    AST_ABORT_B1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL1 && reg_wdata == '0 && busy[1]) |=> !busy[1]); // R10

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_ERR && !reg_wr) |=> (err == '0)); // R12

    AST_STALL_B0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_bank && reg_addr == A_CTRL0 && reg_rdata != '0) |-> !rd_ready); // R11

endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rd_req    (rd_req),
    .rd_bank   (rd_bank),
    .rd_ready  (rd_ready),
    .key_armed (key_armed),
    .busy      (busy_vec),
    .err       (err_vec)
);

// File: tb/flash_pe_ctrl_tb.sv
module flash_pe_ctrl_tb;

    localparam int NP = 4, PW = 16, NI = 16, NB = 8, EC = 12, PC = 5;
    localparam int AW = $clog2(NP * PW);
    localparam logic [31:0] KEY = 32'hB119_24E1, OER = 32'h3141_5927,
                            OPR = 32'h2718_2818, ORD = 32'h1602_1765;

    logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, rd_req = 0, rd_bank = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, rd_data;
    logic [AW-1:0] rd_addr = 0;
    logic rd_ready;
    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_pe_ctrl #(.PAGES(NP), .PAGE_WORDS(PW), .INFO_WORDS(NI), .BUF_WORDS(NB),
                    .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data));

    typedef struct packed {
        logic        use_key;
        logic        bank;
        logic [31:0] opc;
        logic [15:0] off;
        logic        info;
        logic [7:0]  cnt;
        logic [4:0]  exp_err;
        logic        exp_run;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 1'b0, 32'h1234_5678, 16'd0,  1'b0, 8'd0, 5'b00010, 1'b0},
        '{1'b0, 1'b0, OPR,           16'd0,  1'b0, 8'd0, 5'b00001, 1'b0},
        '{1'b1, 1'b1, OER,           16'd0,  1'b1, 8'd0, 5'b01000, 1'b0},
        '{1'b1, 1'b0, ORD,           16'd0,  1'b1, 8'd0, 5'b01000, 1'b0},
        '{1'b1, 1'b1, ORD,           16'd0,  1'b0, 8'd0, 5'b01000, 1'b0},
        '{1'b1, 1'b0, OPR,           16'd12, 1'b0, 8'd4, 5'b00100, 1'b0},
        '{1'b1, 1'b1, OER,           16'd64, 1'b0, 8'd0, 5'b00100, 1'b0},
        '{1'b1, 1'b1, OPR,           16'd16, 1'b1, 8'd0, 5'b00100, 1'b0},
        '{1'b1, 1'b1, OPR,           16'd60, 1'b0, 8'd3, 5'b00000, 1'b1}
    };

    function automatic logic [31:0] bv(int i);
        return 32'hF0F0_0F0F ^ (32'(i) * 32'h0101_0101);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rdreg(logic [7:0] a, output logic [31:0] v);
        reg_rd = 1; reg_addr = a; #1; v = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic peek(logic [7:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic memrd(logic b, int a, output logic rdy, output logic [31:0] v);
        rd_req = 1; rd_bank = b; rd_addr = AW'(a); #1;
        rdy = rd_ready; v = rd_data; rd_req = 0;
    endtask

    task automatic xfer(int off, logic info, int cnt);
        wr(8'h0C, (32'(cnt) << 24) | (32'(info) << 16) | 32'(off));
    endtask

    task automatic wait_idle(logic b);
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            peek(b ? 8'h08 : 8'h04, v);
            if (v == 0) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic rdy;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        peek(8'h10, v); chk("R1 err", v, 0);
        peek(8'h04, v); chk("R1 ctrl0", v, 0);
        peek(8'h08, v); chk("R1 ctrl1", v, 0);
        memrd(0, 5, rdy, v); chk("R1 word", v, 32'hFFFF_FFFF); chk("R1 ready", 32'(rdy), 1);

        for (int i = 0; i < NB; i++) wr(8'h80 + 8'(4 * i), bv(i));

        // table of rejected and accepted requests
        for (int k = 0; k < 9; k++) begin
            vec_t t;
            string lbl;
            t = VECS[k];
            lbl = t.exp_err[0] ? "R4 table" : t.exp_err[1] ? "R5 table" :
                  t.exp_err[3] ? "R7 table" : "R6 table";
            xfer(int'(t.off), t.info, int'(t.cnt));
            if (t.use_key) wr(8'h00, KEY);
            wr(t.bank ? 8'h08 : 8'h04, t.opc);
            peek(t.bank ? 8'h08 : 8'h04, v); chk(lbl, v, t.exp_run ? t.opc : 0);
            rdreg(8'h10, v); chk(lbl, v, 32'(t.exp_err));
            wait_idle(t.bank);
        end
        memrd(1, 60, rdy, v); chk("R6 last page start", v, bv(0));
        memrd(1, 63, rdy, v); chk("R6 last page end", v, bv(3));

        // R3 / R9 / R11 program three words
        xfer(4, 0, 2); wr(8'h00, KEY); wr(8'h04, OPR);
        repeat (PC - 1) @(negedge clk);
        peek(8'h04, v); chk("R9 prog busy", v, OPR);
        memrd(0, 4, rdy, v); chk("R11 stall", 32'(rdy), 0);
        memrd(1, 0, rdy, v); chk("R11 other bank", 32'(rdy), 1);
        @(negedge clk);
        peek(8'h04, v); chk("R9 prog done", v, 0);
        for (int i = 0; i < 3; i++) begin
            memrd(0, 4 + i, rdy, v); chk("R3 program", v, bv(i));
        end
        memrd(0, 7, rdy, v); chk("R3 past count", v, 32'hFFFF_FFFF);
        memrd(0, 3, rdy, v); chk("R3 before offset", v, 32'hFFFF_FFFF);

        // R3 AND with count 0
        wr(8'h80, 32'h0000_FFFF);
        xfer(4, 0, 0); wr(8'h00, KEY); wr(8'h04, OPR); wait_idle(0);
        memrd(0, 4, rdy, v); chk("R3 and", v, bv(0) & 32'h0000_FFFF);
        memrd(0, 5, rdy, v); chk("R3 single word", v, bv(1));

        // R2 erase page 0, page 1 untouched
        xfer(20, 0, 0); wr(8'h00, KEY); wr(8'h04, OPR); wait_idle(0);
        xfer(5, 0, 0); wr(8'h00, KEY); wr(8'h04, OER);
        repeat (EC - 1) @(negedge clk);
        peek(8'h04, v); chk("R9 erase busy", v, OER);
        @(negedge clk);
        peek(8'h04, v); chk("R9 erase done", v, 0);
        memrd(0, 4, rdy, v); chk("R2 erased", v, 32'hFFFF_FFFF);
        memrd(0, 6, rdy, v); chk("R2 erased", v, 32'hFFFF_FFFF);
        memrd(0, 20, rdy, v); chk("R2 other page", v, 32'h0000_FFFF);

        // R10 abort
        xfer(20, 0, 0); wr(8'h00, KEY); wr(8'h04, OER);
        @(negedge clk);
        wr(8'h04, 0);
        peek(8'h04, v); chk("R10 aborted", v, 0);
        rdreg(8'h10, v); chk("R10 no error", v, 0);
        repeat (EC + 2) @(negedge clk);
        memrd(0, 20, rdy, v); chk("R10 unchanged", v, 32'h0000_FFFF);

        // R4 key spent by a zero control write, and wrong key
        wr(8'h00, KEY); wr(8'h08, 0); xfer(0, 0, 0); wr(8'h08, OPR);
        peek(8'h08, v); chk("R4 key spent", v, 0);
        rdreg(8'h10, v); chk("R4 key spent err", v, 32'h1);
        wr(8'h00, 32'h1234_5678); wr(8'h08, OPR);
        peek(8'h08, v); chk("R4 wrong key", v, 0);
        rdreg(8'h10, v); chk("R4 wrong key err", v, 32'h1);

        // R9 nonzero write while busy
        xfer(0, 0, 0); wr(8'h00, KEY); wr(8'h08, OER);
        wr(8'h00, KEY); wr(8'h08, OPR);
        peek(8'h08, v); chk("R9 still erase", v, OER);
        rdreg(8'h10, v); chk("R9 busy err", v, 32'h10);
        wait_idle(1);

        // R8 info program then info read
        wr(8'h80, 32'h1234_ABCD);
        xfer(3, 1, 0); wr(8'h00, KEY); wr(8'h08, OPR); wait_idle(1);
        xfer(3, 1, 0); wr(8'h00, KEY); wr(8'h08, ORD); wait_idle(1);
        rdreg(8'h14, v); chk("R8 info read", v, 32'h1234_ABCD);
        memrd(1, 3, rdy, v); chk("R8 main untouched", v, 32'hFFFF_FFFF);

        // R12 clear on read
        wr(8'h04, OPR);
        rdreg(8'h10, v); chk("R12 first read", v, 32'h1);
        rdreg(8'h10, v); chk("R12 cleared", v, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule